// File: doc/BRIEF.md
# Seven-Level Stacked-Carrier Gate Generator

This block drives the nine power switches of a single-phase, seven-level switched-capacitor inverter with one DC source. It produces its own half-wave reference from a phase accumulator. The reference is scaled by an unsigned fixed-point modulation index. Its magnitude is compared with three identical triangular carriers. The carriers are stacked one above another, so together they cover three carrier amplitudes. The number of carriers that the magnitude exceeds gives the output level (0 to 3). The reference sign chooses the positive or the negative set of states. The resulting state is registered, and a fixed decoder turns it into the nine gate signals.

The zero level has two codes, one for each half cycle. Both codes turn on the same switches, so every capacitor sits in its charging path. When the block is disabled it parks in the positive-half zero state. The carrier half-period input sets the switching frequency: a half-period of 12500 clocks at a 50 MHz clock gives 2 kHz. An index of 0.85 is 218 in the default Q2.8 format. Dead-time insertion happens downstream. All pins are plain control and status pins; there is no streaming interface, so no back-pressure applies.

Top module: `spwm7_gate_gen`

## Requirements
- R1: While rst_n is low, and on every clock edge where en is low, the next state code is 0 and gate_o is 9'h0DB (switches 1, 2, 4, 5, 7, 8 on). The phase and the carrier restart at 0, with the carrier counting upward.
- R2: state_o is {sign, level}: code 0 zero (positive half), 1 +0.5, 2 +1.0, 3 +1.5, 4 zero (negative half), 5 -0.5, 6 -1.0, 7 -1.5. Bit i-1 of gate_o drives switch i. The switches that are on are: zero {1,2,4,5,7,8}, +0.5 {1,2,4,5,6}, +1.0 {1,3,5,7,8}, +1.5 {1,3,5,6}, -0.5 {1,2,4,5,9}, -1.0 {2,3,4,7,8}, -1.5 {2,3,4,9}. Every other switch is off.
- R3: In every state, switch 5 equals switch 1, switch 4 equals switch 2, and switch 8 equals switch 7. Exactly one of switches 6, 7 and 9 is on.
- R4: The carrier base tri runs 0, 1, ..., A, A-1, ..., 1, 0 and then repeats, where A is carrier_half. It moves one step per enabled clock, so its period is 2A clocks. Carrier k (k = 0, 1, 2) equals tri + k*A.
- R5: On each enabled clock, the phase register ph (PH_W bits) advances by freq_word. The sign is the top bit of ph. With h = the low PH_W-1 bits of ph and H = 2^(PH_W-1), the shape is s = floor(4*h*(H-h)/H). The magnitude is floor(s * mod_index * 3A / 2^(PH_W-1+MI_FRAC)).
- R6: level is the number of carriers that the magnitude strictly exceeds. The state {sign, level} is computed from the ph and tri values held before a clock edge and appears on state_o after that edge.
- R7: When mod_index is above 1.0, the magnitude near the peak exceeds the top carrier everywhere, and the state reaches level 3 (+1.5 or -1.5).
- R8: In the negative half, level 0 is reported as code 4, not code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| en | input | 1 | run enable; low parks the block in the positive zero state |
| mod_index | input | MI_W | modulation index, unsigned, MI_FRAC fractional bits |
| freq_word | input | PH_W | phase increment per clock |
| carrier_half | input | CNT_W | carrier amplitude A, in clocks per half period |
| gate_o | output | 9 | gate signals, bit i-1 drives switch i |
| state_o | output | 3 | active state code {sign, level} |

## Verification
The bench builds the block with a 10-bit phase and a 6-bit carrier. At these widths one reference period is 28 to 128 clocks, and a carrier period is only a few clocks. This lets the bench sweep every combination of three carrier amplitudes (including A=1), five modulation indices from 0.25 to 2.0, and two frequency words. It predicts the state and the gate vector on every clock. The sweep reaches both zero codes, all six non-zero levels, and saturation in over-modulation. It also covers enable drops and a reset in the middle of a run, and carriers only one step high.

// File: rtl/spwm7_pkg.sv
package spwm7_pkg;
  localparam int NSW  = 9;
  localparam int NCAR = 3;
  localparam int NST  = 8;

  typedef enum logic [2:0] {
    ST_ZP = 3'd0, ST_P1 = 3'd1, ST_P2 = 3'd2, ST_P3 = 3'd3,
    ST_ZN = 3'd4, ST_N1 = 3'd5, ST_N2 = 3'd6, ST_N3 = 3'd7
  } st_e;

  // switches turned on per state, bit i-1 = switch i
  function automatic logic [NSW-1:0] on_set(input int unsigned code);
    case (code)
      0, 4:    on_set = 9'b011011011;
      1:       on_set = 9'b000111011;
      2:       on_set = 9'b011010101;
      3:       on_set = 9'b000110101;
      5:       on_set = 9'b100011011;
      6:       on_set = 9'b011001110;
      default: on_set = 9'b100001110;
    endcase
  endfunction
endpackage

// File: rtl/spwm7_refgen.sv
module spwm7_refgen #(
  parameter int PH_W    = 16,
  parameter int CNT_W   = 14,
  parameter int MI_W    = 10,
  parameter int MI_FRAC = 8,
  localparam int SH     = PH_W - 1,
  localparam int MAG_W  = PH_W + MI_W + CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [PH_W-1:0]  freq_word,
  input  logic [MI_W-1:0]  mod_index,
  input  logic [CNT_W-1:0] amp,
  output logic             sign_o,
  output logic [MAG_W-1:0] mag_o
);
  logic [PH_W-1:0]  ph_q;
  logic [SH-1:0]    h;
  logic [SH:0]      hc;
  logic [2*SH:0]    sq;
  logic [SH:0]      shape;
  logic [CNT_W+1:0] amp3;
  logic [MAG_W-1:0] full;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) ph_q <= '0;
    else               ph_q <= ph_q + freq_word;
  end

  always_comb begin
    h     = ph_q[SH-1:0];
    hc    = {1'b1, {SH{1'b0}}} - {1'b0, h};
    sq    = {{(SH+1){1'b0}}, h} * {{SH{1'b0}}, hc};
    shape = (SH+1)'(sq >> (SH-2));
    amp3  = {2'b00, amp} + {1'b0, amp, 1'b0};
    full  = MAG_W'(shape) * MAG_W'(mod_index) * MAG_W'(amp3);
    mag_o = full >> (SH + MI_FRAC);
  end

  assign sign_o = ph_q[PH_W-1];

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> ph_q == $past(ph_q) + $past(freq_word)); // R5
endmodule

// File: rtl/spwm7_carrier.sv
module spwm7_carrier #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] amp,
  output logic [CNT_W-1:0] tri_o
);
  logic [CNT_W-1:0] tri_q;
  logic             up_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      tri_q <= '0;
      up_q  <= 1'b1;
    end else if (up_q) begin
      if ({1'b0, tri_q} + 1'b1 >= {1'b0, amp}) begin
        tri_q <= amp;
        up_q  <= 1'b0;
      end else begin
        tri_q <= tri_q + 1'b1;
      end
    end else begin
      if (tri_q <= CNT_W'(1)) begin
        tri_q <= '0;
        up_q  <= 1'b1;
      end else begin
        tri_q <= tri_q - 1'b1;
      end
    end
  end

  assign tri_o = tri_q;

  AST_TRI_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(amp) && tri_q <= amp) |=> tri_q <= amp); // R4

  AST_TRI_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $stable(amp) && tri_q <= amp) |=>
      (tri_q == $past(tri_q) + 1'b1) || (tri_q + 1'b1 == $past(tri_q)) ||
      (tri_q == $past(tri_q))); // R4
endmodule

// File: rtl/spwm7_state_sel.sv
module spwm7_state_sel
  import spwm7_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int MAG_W = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             sign,
  input  logic [MAG_W-1:0] mag,
  input  logic [CNT_W-1:0] tri_v,
  input  logic [CNT_W-1:0] amp,
  output st_e              state_o
);
  logic [NCAR-1:0] above;
  logic [1:0]      level;
  st_e             state_q;

  for (genvar k = 0; k < NCAR; k++) begin : g_car
    logic [CNT_W+1:0] car;
    assign car      = {2'b00, tri_v} + (CNT_W+2)'(k) * {2'b00, amp};
    assign above[k] = mag > MAG_W'(car);
  end

  always_comb begin
    level = '0;
    for (int k = 0; k < NCAR; k++) level = level + 2'(above[k]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) state_q <= ST_ZP;
    else               state_q <= st_e'({sign, level});
  end

  assign state_o = state_q;

  AST_NO_REF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mag == '0) |=> state_q[1:0] == 2'd0); // R6
endmodule

// File: rtl/spwm7_gate_decode.sv
module spwm7_gate_decode
  import spwm7_pkg::*;
(
  input  st_e            state,
  output logic [NSW-1:0] gate_o
);
  logic [NST-1:0] hot;

  for (genvar s = 0; s < NST; s++) begin : g_hot
    assign hot[s] = (state == st_e'(s));
  end

  for (genvar w = 0; w < NSW; w++) begin : g_sw
    logic [NST-1:0] use_st;
    for (genvar s = 0; s < NST; s++) begin : g_col
      localparam logic [NSW-1:0] MASK = on_set(s);
      assign use_st[s] = MASK[w];
    end
    assign gate_o[w] = |(hot & use_st);
  end
endmodule

// File: rtl/spwm7_gate_gen.sv
module spwm7_gate_gen
  import spwm7_pkg::*;
#(
  parameter int PH_W    = 16,
  parameter int CNT_W   = 14,
  parameter int MI_W    = 10,
  parameter int MI_FRAC = 8,
  localparam int MAG_W  = PH_W + MI_W + CNT_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [MI_W-1:0]  mod_index,
  input  logic [PH_W-1:0]  freq_word,
  input  logic [CNT_W-1:0] carrier_half,
  output logic [8:0]       gate_o,
  output logic [2:0]       state_o
);
  logic             sign;
  logic [MAG_W-1:0] mag;
  logic [CNT_W-1:0] tri_v;
  st_e              state;

  spwm7_refgen #(.PH_W(PH_W), .CNT_W(CNT_W), .MI_W(MI_W), .MI_FRAC(MI_FRAC)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(en), .freq_word(freq_word),
    .mod_index(mod_index), .amp(carrier_half), .sign_o(sign), .mag_o(mag));

  spwm7_carrier #(.CNT_W(CNT_W)) u_car (
    .clk(clk), .rst_n(rst_n), .en(en), .amp(carrier_half), .tri_o(tri_v));

  spwm7_state_sel #(.CNT_W(CNT_W), .MAG_W(MAG_W)) u_sel (
    .clk(clk), .rst_n(rst_n), .en(en), .sign(sign), .mag(mag),
    .tri_v(tri_v), .amp(carrier_half), .state_o(state));

  spwm7_gate_decode u_dec (.state(state), .gate_o(gate_o));

  assign state_o = state;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (state_o == 3'd0 && gate_o == 9'h0DB)); // R1

  AST_PAIR_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o[0] == gate_o[4]) && (gate_o[1] == gate_o[3]) && (gate_o[6] == gate_o[7])); // R3

  AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({gate_o[8], gate_o[6], gate_o[5]}) == 1); // R3

  AST_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o[2] && state_o[1:0] == 2'd0) |-> gate_o == 9'h0DB); // R8
endmodule

// File: tb/test_spwm7_gate_gen.sv
module test_spwm7_gate_gen;
  localparam int PH_W = 10, CNT_W = 6, MI_W = 10, MI_FRAC = 8;
  localparam longint H = 64'd1 << (PH_W - 1);

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [MI_W-1:0]  mod_index = '0;
  logic [PH_W-1:0]  freq_word = '0;
  logic [CNT_W-1:0] carrier_half = '0;
  logic [8:0] gate_o;
  logic [2:0] state_o;

  int checks = 0, fails = 0;
  longint m_ph = 0, m_tri = 0;
  bit m_up = 1'b1;
  int exp_st = 0;
  int seen[8];
  int max_lvl;

  always #10 clk = ~clk;

  spwm7_gate_gen #(.PH_W(PH_W), .CNT_W(CNT_W), .MI_W(MI_W), .MI_FRAC(MI_FRAC)) i_spwm7_gate_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .mod_index(mod_index), .freq_word(freq_word),
    .carrier_half(carrier_half), .gate_o(gate_o), .state_o(state_o));

  function automatic logic [8:0] mask_of(input int st);
    logic [8:0] m = '0;
    int on[$];
    case (st)
      0, 4: on = '{1, 2, 4, 5, 7, 8};
      1:    on = '{1, 2, 4, 5, 6};
      2:    on = '{1, 3, 5, 7, 8};
      3:    on = '{1, 3, 5, 6};
      5:    on = '{1, 2, 4, 5, 9};
      6:    on = '{2, 3, 4, 7, 8};
      default: on = '{2, 3, 4, 9};
    endcase
    foreach (on[i]) m[on[i]-1] = 1'b1;
    return m;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int predict();
    longint a = carrier_half, h, s, mag;
    int lvl = 0;
    h   = m_ph % H;
    s   = (4 * h * (H - h)) / H;
    mag = (s * mod_index * 3 * a) / (H * (64'd1 << MI_FRAC));
    for (int k = 0; k < 3; k++) if (mag > m_tri + k * a) lvl++;
    return ((m_ph / H) % 2) * 4 + lvl;
  endfunction

  task automatic model_restart();
    m_ph = 0; m_tri = 0; m_up = 1'b1;
  endtask

  // one clock: predict at the edge, then compare at the following falling edge
  task automatic step();
    @(posedge clk);
    if (!rst_n || !en) begin
      exp_st = 0;
      model_restart();
    end else begin
      exp_st = predict();
      m_ph = (m_ph + freq_word) % (2 * H);
      if (m_up) begin
        if (m_tri + 1 >= carrier_half) begin m_tri = carrier_half; m_up = 1'b0; end
        else m_tri = m_tri + 1;
      end else begin
        if (m_tri <= 1) begin m_tri = 0; m_up = 1'b1; end
        else m_tri = m_tri - 1;
      end
    end
    @(negedge clk);
    check("R6 R5 R4 state", state_o, exp_st);
    check("R2 gates", gate_o, mask_of(exp_st));
    check("R3 ties", {gate_o[0] ^ gate_o[4], gate_o[1] ^ gate_o[3], gate_o[6] ^ gate_o[7]}, 0);
    seen[state_o]++;
    if (state_o[1:0] > max_lvl) max_lvl = state_o[1:0];
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int amps[3] = '{1, 5, 9};
    int mis[5]  = '{64, 218, 256, 320, 512};
    int fws[2]  = '{8, 37};
    carrier_half = 6'd5; mod_index = 10'd218; freq_word = 10'd8;
    repeat (3) step();
    check("R1 reset state", state_o, 0);
    check("R1 reset gates", gate_o, 9'h0DB);
    @(negedge clk); rst_n = 1'b1;
    foreach (amps[ai]) foreach (mis[mi]) foreach (fws[fi]) begin
      @(negedge clk);
      en = 1'b0; carrier_half = CNT_W'(amps[ai]); mod_index = MI_W'(mis[mi]);
      freq_word = PH_W'(fws[fi]);
      step();
      check("R1 disabled state", state_o, 0);
      check("R1 disabled gates", gate_o, 9'h0DB);
      en = 1'b1;
      foreach (seen[i]) seen[i] = 0;
      max_lvl = 0;
      for (int c = 0; c < 2 * 1024 / fws[fi] + 8; c++) begin
        if (c == 70) en = 1'b0;
        if (c == 73) en = 1'b1;
        step();
      end
      check("R8 negative zero code seen", seen[4] > 0, 1);
      if (mis[mi] > 256) check("R7 saturation level 3", max_lvl, 3);
      if (mis[mi] == 64) check("R6 low index stays below level 2", max_lvl <= 1, 1);
    end
    // reset in the middle of a run
    @(negedge clk); rst_n = 1'b0;
    step();
    check("R1 mid-run reset state", state_o, 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (40) step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule